// File: doc/BRIEF.md
# Majority-Logic Decimal Digit Adder

A purely combinational adder for one decimal digit. It takes two 4-bit digits in binary-coded decimal (values 0 to 9) and a carry-in bit. It returns one 4-bit digit and a decimal carry-out. The inputs pass first through a binary ripple stage. A detector then decides whether the binary total lies outside the decimal range. When it does, a second ripple stage adds six, and the decimal carry-out is raised.

Every logic function in the datapath is built from a three-input majority cell, a five-input majority cell or an inverter:

- Each full-adder carry is a three-input majority of its operands.
- Each full-adder sum is a five-input majority that takes the inverted carry twice.
- AND and OR are three-input majority cells with one input tied to 0 or to 1.

Wider decimal adders are built by wiring the carry-out of one instance to the carry-in of the next more significant instance.

Top module: `maj_bcd_digit_adder`

## Requirements
- R1: When A + B + carry-in is 9 or less, the output digit equals that total in plain binary and carry-out is 0 (example: 2 + 3 + 0 gives digit 4'b0101, carry 0).
- R2: When A + B + carry-in lies between 10 and 19, the output digit equals the total minus 10, and carry-out is 1. Examples: 5 + 5 + 0 gives digit 0 with carry 1, and 9 + 9 + 1 gives digit 9 with carry 1.
- R3: Carry-out is 1 exactly when the six-correction is applied. This happens when the binary stage produces a carry out of bit 3, or when its 4-bit result exceeds 9.
- R4: Carry-in counts as one unit. Two instances chained low-to-high, with the low instance's carry-out driving the high instance's carry-in, form a correct two-digit decimal adder, up to 99 + 99 + 1 = 199.
- R5: The block holds no state and has no clock. Its outputs follow a change on the inputs within the same clock phase.
- R6: For valid inputs (both digits 9 or less), the output digit is never above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dig_a | input | 4 | First addend digit, binary-coded decimal |
| dig_b | input | 4 | Second addend digit, binary-coded decimal |
| carry_in | input | 1 | Decimal carry from the next less significant digit |
| dig_sum | output | 4 | Result digit, binary-coded decimal |
| carry_out | output | 1 | Decimal carry to the next more significant digit |

## Verification
The two functions that meet on the same input change are the binary carry out of bit 3 and the greater-than-nine detection. Either one alone must trigger the add-six path. Totals from 16 to 19 (for example 9 + 8 + 1) raise the binary carry while leaving a small 4-bit result. Totals from 10 to 15 raise only the magnitude term. The bench drives both groups and judges the outputs against a decimal reference, with the digit taken modulo ten and the carry from integer division. A two-instance chain also has the carry-in from the low digit arriving on a high digit that is itself at 9, which makes the correction ripple across digits.

// File: rtl/maj_bcd_pkg.sv
package maj_bcd_pkg;

    localparam int DIGIT_W   = 4;
    localparam int RADIX     = 10;
    localparam int CORR_STEP = (1 << DIGIT_W) - RADIX;

    typedef struct packed {
        logic               carry;
        logic [DIGIT_W-1:0] bits;
    } bin_total_t;

    typedef struct packed {
        logic               carry;
        logic [DIGIT_W-1:0] digit;
    } dec_result_t;

    function automatic dec_result_t dec_reference(input logic [DIGIT_W-1:0] a,
                                                  input logic [DIGIT_W-1:0] b,
                                                  input logic               ci);
        int unsigned t;
        dec_result_t r;
        t       = int'(a) + int'(b) + int'(ci);
        r.carry = (t >= RADIX);
        r.digit = DIGIT_W'(t % RADIX);
        return r;
    endfunction

endpackage

// File: rtl/maj3_cell.sv
module maj3_cell (
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic vote
);
    assign vote = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
endmodule

// File: rtl/maj5_cell.sv
module maj5_cell (
    input  logic [4:0] ins,
    output logic       vote
);
    logic [2:0] ones;
    always_comb begin
        ones = '0;
        for (int i = 0; i < 5; i++) begin
            ones = ones + 3'(ins[i]);
        end
    end
    assign vote = (ones >= 3'd3);
endmodule

// File: rtl/maj_gate2.sv
module maj_gate2 #(
    parameter bit TIE_HIGH = 1'b0
) (
    input  logic op_a,
    input  logic op_b,
    output logic res
);
    localparam logic TIE = TIE_HIGH;

    maj3_cell u_cell (
        .in_a (op_a),
        .in_b (op_b),
        .in_c (TIE),
        .vote (res)
    );
endmodule

// File: rtl/maj_full_adder.sv
module maj_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic cout_n;

    maj3_cell u_carry (
        .in_a (x),
        .in_b (y),
        .in_c (cin),
        .vote (cout)
    );

    assign cout_n = ~cout;

    maj5_cell u_sum (
        .ins  ({x, y, cin, cout_n, cout_n}),
        .vote (sum)
    );

    // R1
    always_comb begin
        fa_arith_chk: assert ({cout, sum} == (2'(x) + 2'(y) + 2'(cin)))
            else $error("full adder arithmetic mismatch");
    end
endmodule

// File: rtl/maj_ripple_adder.sv
module maj_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        maj_full_adder u_fa (
            .x    (op_a[i]),
            .y    (op_b[i]),
            .cin  (chain[i]),
            .sum  (sum[i]),
            .cout (chain[i+1])
        );
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/maj_corr_detect.sv
module maj_corr_detect
    import maj_bcd_pkg::*;
(
    input  bin_total_t total,
    output logic       need_corr
);
    logic mid_or;
    logic high_and;

    maj_gate2 #(.TIE_HIGH(1'b1)) u_or_mid (
        .op_a (total.bits[2]),
        .op_b (total.bits[1]),
        .res  (mid_or)
    );

    maj_gate2 #(.TIE_HIGH(1'b0)) u_and_top (
        .op_a (total.bits[3]),
        .op_b (mid_or),
        .res  (high_and)
    );

    maj_gate2 #(.TIE_HIGH(1'b1)) u_or_carry (
        .op_a (total.carry),
        .op_b (high_and),
        .res  (need_corr)
    );

    // R3
    always_comb begin
        corr_need_chk: assert (need_corr == (int'(total) >= RADIX))
            else $error("correction decision disagrees with binary total");
    end
endmodule

// File: rtl/maj_bcd_digit_adder.sv
module maj_bcd_digit_adder
    import maj_bcd_pkg::*;
(
    input  logic [3:0] dig_a,
    input  logic [3:0] dig_b,
    input  logic       carry_in,
    output logic [3:0] dig_sum,
    output logic       carry_out
);
    bin_total_t         raw;
    logic               need_corr;
    logic [DIGIT_W-1:0] corr_addend;
    logic               corr_spill;

    maj_ripple_adder #(.WIDTH(DIGIT_W)) u_bin_stage (
        .op_a (dig_a),
        .op_b (dig_b),
        .cin  (carry_in),
        .sum  (raw.bits),
        .cout (raw.carry)
    );

    maj_corr_detect u_detect (
        .total     (raw),
        .need_corr (need_corr)
    );

    for (genvar i = 0; i < DIGIT_W; i++) begin : g_addend
        if (CORR_STEP[i]) begin : g_one
            assign corr_addend[i] = need_corr;
        end else begin : g_zero
            assign corr_addend[i] = 1'b0;
        end
    end

    maj_ripple_adder #(.WIDTH(DIGIT_W)) u_fix_stage (
        .op_a (raw.bits),
        .op_b (corr_addend),
        .cin  (1'b0),
        .sum  (dig_sum),
        .cout (corr_spill)
    );

    assign carry_out = need_corr;

    // R3
    always_comb begin
        corr_drop_chk: assert (corr_spill == (need_corr & ~raw.carry))
            else $error("correction stage spill bit inconsistent");
    end

    // R2
    always_comb begin
        if (dig_a < 4'd10 && dig_b < 4'd10) begin
            dec_value_chk: assert ({carry_out, dig_sum} ==
                                   dec_reference(dig_a, dig_b, carry_in))
                else $error("decimal result mismatch");
        end
    end

    // R6
    always_comb begin
        if (dig_a < 4'd10 && dig_b < 4'd10) begin
            digit_valid_chk: assert (dig_sum < 4'd10)
                else $error("output digit out of range");
        end
    end
endmodule

// File: tb/maj_bcd_digit_adder_tb.sv
module maj_bcd_digit_adder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;

    // {a, b, cin, expected digit, expected carry}
    localparam logic [13:0] VEC [N_VEC] = '{
        {4'd2, 4'd3, 1'b0, 4'd5, 1'b0},
        {4'd9, 4'd0, 1'b0, 4'd9, 1'b0},
        {4'd4, 4'd4, 1'b1, 4'd9, 1'b0},
        {4'd0, 4'd0, 1'b0, 4'd0, 1'b0},
        {4'd5, 4'd5, 1'b0, 4'd0, 1'b1},
        {4'd8, 4'd7, 1'b0, 4'd5, 1'b1},
        {4'd9, 4'd9, 1'b1, 4'd9, 1'b1},
        {4'd0, 4'd9, 1'b1, 4'd0, 1'b1},
        {4'd9, 4'd8, 1'b1, 4'd8, 1'b1},
        {4'd6, 4'd6, 1'b0, 4'd2, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_lo = '0, b_lo = '0, a_hi = '0, b_hi = '0;
    logic       cin_lo = 1'b0;
    logic [3:0] s_lo, s_hi;
    logic       c_mid, c_hi;
    int         n_run  = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    maj_bcd_digit_adder u_dut (
        .dig_a     (a_lo),
        .dig_b     (b_lo),
        .carry_in  (cin_lo),
        .dig_sum   (s_lo),
        .carry_out (c_mid)
    );

    maj_bcd_digit_adder u_dut_hi (
        .dig_a     (a_hi),
        .dig_b     (b_hi),
        .carry_in  (c_mid),
        .dig_sum   (s_hi),
        .carry_out (c_hi)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply_lo(input int a, input int b, input int ci);
        @(negedge clk);
        a_lo   = 4'(a);
        b_lo   = 4'(b);
        cin_lo = ci[0];
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R5: zero inputs give zero outputs with no clock edge seen
        #1;
        check("R5 idle digit", int'(s_lo), 0);
        check("R5 idle carry", int'(c_mid), 0);
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < N_VEC; i++) begin
            apply_lo(int'(VEC[i][13:10]), int'(VEC[i][9:6]), int'(VEC[i][5]));
            check(VEC[i][0] ? "R2 table digit" : "R1 table digit",
                  int'(s_lo), int'(VEC[i][4:1]));
            check("R3 table carry", int'(c_mid), int'(VEC[i][0]));
        end

        // Exhaustive valid digits and carry-in
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int t;
                    apply_lo(a, b, ci);
                    t = a + b + ci;
                    check(t >= 10 ? "R2 sweep digit" : "R1 sweep digit",
                          int'(s_lo), t % 10);
                    check("R3 sweep carry", int'(c_mid), t / 10);
                    check("R6 sweep range", int'(s_lo < 4'd10), 1);
                end
            end
        end

        // R5: output follows input change within the same low phase
        @(negedge clk);
        a_lo = 4'd7; b_lo = 4'd1; cin_lo = 1'b0;
        #1;
        check("R5 settle 8", int'(s_lo), 8);
        a_lo = 4'd7; b_lo = 4'd3;
        #1;
        check("R5 settle 10 digit", int'(s_lo), 0);
        check("R5 settle 10 carry", int'(c_mid), 1);

        // R4: two-digit chain
        for (int x = 0; x < 100; x += 7) begin
            for (int y = 0; y < 100; y += 3) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int t;
                    int got;
                    @(negedge clk);
                    a_lo = 4'(x % 10); a_hi = 4'(x / 10);
                    b_lo = 4'(y % 10); b_hi = 4'(y / 10);
                    cin_lo = ci[0];
                    #1;
                    t   = x + y + ci;
                    got = int'(c_hi) * 100 + int'(s_hi) * 10 + int'(s_lo);
                    check("R4 chain", got, t);
                end
            end
        end

        // R4: ripple through a high digit sitting at 9
        @(negedge clk);
        a_lo = 4'd9; b_lo = 4'd9; cin_lo = 1'b1;
        a_hi = 4'd9; b_hi = 4'd9;
        #1;
        check("R4 199", int'(c_hi) * 100 + int'(s_hi) * 10 + int'(s_lo), 199);
        @(negedge clk);
        a_lo = 4'd9; b_lo = 4'd0; cin_lo = 1'b1;
        a_hi = 4'd9; b_hi = 4'd0;
        #1;
        check("R4 099+1", int'(c_hi) * 100 + int'(s_hi) * 10 + int'(s_lo), 100);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule